// File: doc/BRIEF.md
# Bus Address Window Translator

The translator maps addresses between two buses through a bank of programmable windows. Each window holds four registers: a control word that gates it and names the address space it covers, a start address, a bound address and an offset. For a lookup, the block tests every window in parallel. A hit needs three things: the window is enabled, the window's address-space mode equals the requested mode exactly, and the address falls inside the window's half-open range. The lowest-numbered window that hits wins.

A lookup runs in one of two directions. A reverse lookup compares the incoming address against the range and adds the offset. A forward lookup subtracts the offset first, compares the difference against the range and returns that difference. All offset arithmetic wraps modulo 2^32.

Windows 0 and 4 have 4 KB granularity and all other windows have 64 KB granularity. A parameter can shrink the live bank to four windows, which models an earlier revision. Software writes the range registers first and the control word last, because any range write switches the window off.

Top module: `xlat_window_bank`

## Requirements
- R1: Register block of window w starts at word address 5*w. Slot 0 is control, 1 is start, 2 is bound and 3 is offset. Slot 4, and every word at or above 5*NUM_WIN, reads zero. The control word keeps only bit 31 (enable), bits 18:16 (space: 0 = 16-bit, 1 = 24-bit, 2 = 32-bit), bit 14 (program) and bit 12 (supervisor). Its other bits read zero.
- R2: Start, bound and offset keep bits 31:12 in windows 0 and 4 and bits 31:16 in all other windows. Lower bits read zero and play no part in compares.
- R3: A window whose enable bit is clear never hits.
- R4: A window hits only if its {space, program, supervisor} bits equal lk_mode, which is encoded {space[2:0], program, supervisor}.
- R5: A reverse lookup (lk_reverse = 1) hits when start <= addr < bound and returns addr + offset.
- R6: A forward lookup (lk_reverse = 0) forms x = addr - offset, hits when start <= x < bound, and returns x.
- R7: Offset addition and subtraction wrap modulo 2^32.
- R8: When several windows hit, rs_win names the lowest-numbered one and rs_addr is that window's result.
- R9: The result appears one cycle after the request, with rs_valid set for exactly that cycle. On a miss, or when no request is made, rs_hit, rs_win and rs_addr are zero. After reset all result outputs and all registers are zero.
- R10: With LIVE_WINDOWS = 4, windows 4 to 7 never hit.
- R11: A write to a window's start, bound or offset clears that window's enable bit and leaves its other control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register word address, also the read address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational readback of the word at cfg_addr |
| lk_valid | input | 1 | Lookup request |
| lk_reverse | input | 1 | 1 = reverse lookup, 0 = forward lookup |
| lk_mode | input | 5 | Requested mode {space[2:0], program, supervisor} |
| lk_addr | input | 32 | Address to translate |
| rs_valid | output | 1 | Result strobe, one cycle after lk_valid |
| rs_hit | output | 1 | A window matched |
| rs_win | output | WIN_W | Index of the winning window |
| rs_addr | output | 32 | Translated address |

## Verification
The checker watches every cycle for the following:
- the result strobe follows the request by exactly one cycle;
- a miss leaves the index and address at zero;
- a reported hit always names a window that was enabled;
- no hit ever lands beyond the live window count;
- any range-register write leaves that window disabled.

Only the bench's scenarios can show the following:
- the translated values themselves, including wraparound in both directions;
- the exact mode match;
- the inclusive start and exclusive bound edges;
- granularity masking on readback and in compares;
- lowest-index priority among overlapping windows;
- the four-window variant.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int unsigned ADDR_W      = 32;
    localparam int unsigned EN_BIT      = 31;
    localparam int unsigned SPACE_LSB   = 16;
    localparam int unsigned PGM_BIT     = 14;
    localparam int unsigned SUP_BIT     = 12;
    localparam int unsigned FINE_BITS   = 12;
    localparam int unsigned COARSE_BITS = 16;
    localparam int unsigned FINE_PERIOD = 4;

    typedef struct packed {
        logic [2:0] space;
        logic       pgm;
        logic       sup;
    } as_mode_t;

    typedef struct packed {
        logic     en;
        as_mode_t mode;
    } win_ctrl_t;

    typedef struct packed {
        win_ctrl_t         ctrl;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] bound;
        logic [ADDR_W-1:0] offset;
    } win_cfg_t;

    typedef enum logic [1:0] {
        SLOT_CTRL   = 2'd0,
        SLOT_START  = 2'd1,
        SLOT_BOUND  = 2'd2,
        SLOT_OFFSET = 2'd3
    } slot_e;

    function automatic logic [ADDR_W-1:0] gran_mask(int unsigned idx);
        logic [ADDR_W-1:0] m;
        m = '1;
        if (idx % FINE_PERIOD == 0) m = m << FINE_BITS;
        else                        m = m << COARSE_BITS;
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] ctrl_to_word(win_ctrl_t c);
        logic [ADDR_W-1:0] w;
        w = '0;
        w[EN_BIT]                   = c.en;
        w[SPACE_LSB +: 3]           = c.mode.space;
        w[PGM_BIT]                  = c.mode.pgm;
        w[SUP_BIT]                  = c.mode.sup;
        return w;
    endfunction

    function automatic win_ctrl_t word_to_ctrl(logic [ADDR_W-1:0] w);
        win_ctrl_t c;
        c.en         = w[EN_BIT];
        c.mode.space = w[SPACE_LSB +: 3];
        c.mode.pgm   = w[PGM_BIT];
        c.mode.sup   = w[SUP_BIT];
        return c;
    endfunction

endpackage

// File: rtl/xlat_regbank.sv
module xlat_regbank
    import xlat_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int STRIDE  = 5,
    parameter int CAW     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CAW-1:0]    addr,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output win_cfg_t          cfg [NUM_WIN]
);

    logic [NUM_WIN-1:0][ADDR_W-1:0] rd_part;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [CAW-1:0]    BASE = CAW'(w * STRIDE);
        localparam logic [ADDR_W-1:0] MASK = gran_mask(w);

        logic [CAW-1:0] rel;
        logic           in_blk;
        win_cfg_t       r;

        assign rel    = addr - BASE;
        assign in_blk = (addr >= BASE) && (rel < CAW'(STRIDE));

        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (we && in_blk) begin
                case (rel)
                    CAW'(SLOT_CTRL): r.ctrl <= word_to_ctrl(wdata);
                    CAW'(SLOT_START): begin
                        r.start   <= wdata & MASK;
                        r.ctrl.en <= 1'b0;
                    end
                    CAW'(SLOT_BOUND): begin
                        r.bound   <= wdata & MASK;
                        r.ctrl.en <= 1'b0;
                    end
                    CAW'(SLOT_OFFSET): begin
                        r.offset  <= wdata & MASK;
                        r.ctrl.en <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end

        always_comb begin
            rd_part[w] = '0;
            if (in_blk) begin
                case (rel)
                    CAW'(SLOT_CTRL):   rd_part[w] = ctrl_to_word(r.ctrl);
                    CAW'(SLOT_START):  rd_part[w] = r.start;
                    CAW'(SLOT_BOUND):  rd_part[w] = r.bound;
                    CAW'(SLOT_OFFSET): rd_part[w] = r.offset;
                    default:           rd_part[w] = '0;
                endcase
            end
        end

        assign cfg[w] = r;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) rdata = rdata | rd_part[i];
    end

endmodule

// File: rtl/xlat_window_match.sv
module xlat_window_match
    import xlat_pkg::*;
#(
    parameter int IDX          = 0,
    parameter int LIVE_WINDOWS = 8
) (
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    input  as_mode_t          mode,
    input  logic              reverse,
    output logic              hit,
    output logic [ADDR_W-1:0] xaddr
);

    localparam logic LIVE = (IDX < LIVE_WINDOWS);

    logic [ADDR_W-1:0] cand;
    logic              in_rng;
    logic              mode_ok;

    assign cand    = reverse ? addr : addr - cfg.offset;
    assign in_rng  = (cand >= cfg.start) && (cand < cfg.bound);
    assign mode_ok = (cfg.ctrl.mode == mode);
    assign hit     = LIVE & cfg.ctrl.en & mode_ok & in_rng;
    assign xaddr   = reverse ? addr + cfg.offset : cand;

endmodule

// File: rtl/xlat_first_hit.sv
module xlat_first_hit #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end

    assign any = |hits;

endmodule

// File: rtl/xlat_window_bank.sv
module xlat_window_bank
    import xlat_pkg::*;
#(
    parameter  int NUM_WIN      = 8,
    parameter  int LIVE_WINDOWS = 8,
    parameter  int REG_STRIDE   = 5,
    localparam int CFG_AW       = $clog2(NUM_WIN * REG_STRIDE),
    localparam int WIN_W        = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              lk_valid,
    input  logic              lk_reverse,
    input  logic [4:0]        lk_mode,
    input  logic [31:0]       lk_addr,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic [WIN_W-1:0]  rs_win,
    output logic [31:0]       rs_addr
);

    win_cfg_t                       cfg [NUM_WIN];
    logic [NUM_WIN-1:0]             hits;
    logic [NUM_WIN-1:0][ADDR_W-1:0] xaddr;
    logic [NUM_WIN-1:0]             win_en;
    logic                           any_hit;
    logic [WIN_W-1:0]               pick;
    as_mode_t                       req_mode;

    assign req_mode = as_mode_t'(lk_mode);

    xlat_regbank #(
        .NUM_WIN (NUM_WIN),
        .STRIDE  (REG_STRIDE),
        .CAW     (CFG_AW)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        xlat_window_match #(
            .IDX          (w),
            .LIVE_WINDOWS (LIVE_WINDOWS)
        ) u_match (
            .cfg     (cfg[w]),
            .addr    (lk_addr),
            .mode    (req_mode),
            .reverse (lk_reverse),
            .hit     (hits[w]),
            .xaddr   (xaddr[w])
        );
        assign win_en[w] = cfg[w].ctrl.en;
    end

    xlat_first_hit #(
        .N  (NUM_WIN),
        .IW (WIN_W)
    ) u_pick (
        .hits (hits),
        .any  (any_hit),
        .idx  (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_win   <= '0;
            rs_addr  <= '0;
        end else begin
            rs_valid <= lk_valid;
            rs_hit   <= lk_valid & any_hit;
            rs_win   <= (lk_valid & any_hit) ? pick : '0;
            rs_addr  <= (lk_valid & any_hit) ? xaddr[pick] : '0;
        end
    end

endmodule

// File: rtl/xlat_window_checker.sv
module xlat_window_checker #(
    parameter int NUM_WIN      = 8,
    parameter int LIVE_WINDOWS = 8,
    parameter int REG_STRIDE   = 5,
    parameter int CFG_AW       = 6,
    parameter int WIN_W        = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic              lk_valid,
    input logic              rs_valid,
    input logic              rs_hit,
    input logic [WIN_W-1:0]  rs_win,
    input logic [31:0]       rs_addr,
    input logic [NUM_WIN-1:0] win_en
);

    logic [NUM_WIN-1:0] win_en_q;

    always_ff @(posedge clk) begin
        if (rst) win_en_q <= '0;
        else     win_en_q <= win_en;
    end

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rs_valid);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rs_valid);

    a_r9_miss_zero: assert property (@(posedge clk) disable iff (rst)
        !rs_hit |-> (rs_win == '0 && rs_addr == '0));

    a_r3_hit_enabled: assert property (@(posedge clk) disable iff (rst)
        rs_hit |-> win_en_q[rs_win]);

    a_r10_live_only: assert property (@(posedge clk) disable iff (rst)
        rs_hit |-> (int'(rs_win) < LIVE_WINDOWS));

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_clr
        localparam int BASE = w * REG_STRIDE;
        a_r11_range_write_disables: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && int'(cfg_addr) > BASE && int'(cfg_addr) <= BASE + 3)
            |=> !win_en[w]);
    end

endmodule

bind xlat_window_bank xlat_window_checker #(
    .NUM_WIN      (NUM_WIN),
    .LIVE_WINDOWS (LIVE_WINDOWS),
    .REG_STRIDE   (REG_STRIDE),
    .CFG_AW       (CFG_AW),
    .WIN_W        (WIN_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .lk_valid (lk_valid),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_win   (rs_win),
    .rs_addr  (rs_addr),
    .win_en   (win_en)
);

// File: tb/sim_xlat_window_bank.sv
module sim_xlat_window_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata, cfg_rdata1;
    logic        lk_valid = 1'b0;
    logic        lk_reverse = 1'b0;
    logic [4:0]  lk_mode = '0;
    logic [31:0] lk_addr = '0;
    logic        rs_valid, rs_hit, rs_valid1, rs_hit1;
    logic [2:0]  rs_win, rs_win1;
    logic [31:0] rs_addr, rs_addr1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    xlat_window_bank u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
        .lk_reverse(lk_reverse), .lk_mode(lk_mode), .lk_addr(lk_addr),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_win(rs_win), .rs_addr(rs_addr));

    xlat_window_bank #(.LIVE_WINDOWS(4)) u1 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata1), .lk_valid(lk_valid),
        .lk_reverse(lk_reverse), .lk_mode(lk_mode), .lk_addr(lk_addr),
        .rs_valid(rs_valid1), .rs_hit(rs_hit1), .rs_win(rs_win1), .rs_addr(rs_addr1));

    typedef struct packed {
        logic        rev;
        logic [4:0]  mode;
        logic [31:0] addr;
        logic        hit;
        logic [2:0]  win;
        logic [31:0] res;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'h08, 32'h1000_0040, 1'b1, 3'd0, 32'h3000_0040},
        '{1'b1, 5'h08, 32'h1000_FFFF, 1'b1, 3'd0, 32'h3000_FFFF},
        '{1'b1, 5'h08, 32'h1001_0000, 1'b1, 3'd2, 32'h3001_0000},
        '{1'b1, 5'h08, 32'h0FFF_FFFF, 1'b0, 3'd0, 32'h0},
        '{1'b1, 5'h08, 32'h1100_0000, 1'b0, 3'd0, 32'h0},
        '{1'b0, 5'h08, 32'h3000_0010, 1'b1, 3'd0, 32'h1000_0010},
        '{1'b0, 5'h08, 32'h3080_0000, 1'b1, 3'd2, 32'h1080_0000},
        '{1'b1, 5'h05, 32'h0090_0000, 1'b1, 3'd1, 32'h0020_0000},
        '{1'b0, 5'h05, 32'h0010_0000, 1'b1, 3'd1, 32'h0080_0000},
        '{1'b1, 5'h04, 32'h0090_0000, 1'b0, 3'd0, 32'h0},
        '{1'b1, 5'h05, 32'h0080_0000, 1'b1, 3'd1, 32'h0010_0000},
        '{1'b1, 5'h05, 32'h00A0_0000, 1'b0, 3'd0, 32'h0},
        '{1'b1, 5'h02, 32'h0000_1234, 1'b1, 3'd5, 32'h0005_1234},
        '{1'b1, 5'h0A, 32'h1000_0040, 1'b0, 3'd0, 32'h0},
        '{1'b0, 5'h05, 32'h002F_FFFF, 1'b1, 3'd1, 32'h009F_FFFF},
        '{1'b0, 5'h05, 32'h0030_0000, 1'b0, 3'd0, 32'h0}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(string tag, logic [5:0] a, logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    // Request at one posedge, result registered there, sampled next negedge.
    task automatic look(logic rev, logic [4:0] m, logic [31:0] a);
        @(negedge clk);
        lk_valid = 1'b1; lk_reverse = rev; lk_mode = m; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_res(string tag, logic hit, logic [2:0] win, logic [31:0] res);
        check({tag, " valid"}, 32'(rs_valid), 32'd1);
        check({tag, " hit"},   32'(rs_hit),   32'(hit));
        check({tag, " win"},   32'(rs_win),   32'(win));
        check({tag, " addr"},  rs_addr,       res);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        @(negedge clk);
        check("R9 reset rs_valid", 32'(rs_valid), 32'd0);
        check("R9 reset rs_hit", 32'(rs_hit), 32'd0);
        check("R9 reset rs_addr", rs_addr, 32'd0);
        rd("R9 reset ctrl0", 6'd0, 32'd0);
        look(1'b1, 5'h08, 32'h1000_0040);
        expect_res("R3 lookup before config", 1'b0, 3'd0, 32'd0);
        @(negedge clk);
        check("R9 valid one cycle", 32'(rs_valid), 32'd0);

        // Window 0: 4 KB, A32 data user
        wr(6'd1, 32'h1000_0123);
        wr(6'd2, 32'h1001_0000);
        wr(6'd3, 32'h2000_0FFF);
        wr(6'd0, 32'hC0A2_0000);
        // Window 1: 64 KB, A24 supervisor, wrapping offset
        wr(6'd6, 32'h0080_1234);
        wr(6'd7, 32'h00A0_FFFF);
        wr(6'd8, 32'hFF90_0000);
        wr(6'd5, 32'h8001_1000);
        // Window 2: overlaps window 0
        wr(6'd11, 32'h1000_0000);
        wr(6'd12, 32'h1100_0000);
        wr(6'd13, 32'h2000_0000);
        wr(6'd10, 32'h8002_0000);
        // Window 5: A16 program
        wr(6'd26, 32'h0000_0000);
        wr(6'd27, 32'h0001_0000);
        wr(6'd28, 32'h0005_0000);
        wr(6'd25, 32'h8000_4000);

        rd("R1 ctrl keeps defined bits", 6'd0, 32'h8002_0000);
        rd("R1 unused slot zero", 6'd4, 32'd0);
        rd("R1 beyond bank zero", 6'd45, 32'd0);
        rd("R2 fine start", 6'd1, 32'h1000_0000);
        rd("R2 fine offset", 6'd3, 32'h2000_0000);
        rd("R2 coarse start", 6'd6, 32'h0080_0000);
        rd("R2 coarse bound", 6'd7, 32'h00A0_0000);
        rd("R1 w5 ctrl", 6'd25, 32'h8000_4000);

        // Vector table: R2 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            look(VECS[i].rev, VECS[i].mode, VECS[i].addr);
            expect_res($sformatf("R5 R6 R7 R8 vec%0d", i), VECS[i].hit, VECS[i].win, VECS[i].res);
            check($sformatf("R10 four-window vec%0d", i), 32'(rs_hit1),
                  32'(VECS[i].hit && VECS[i].win < 3'd4));
        end

        // R11 range write disables, other control bits kept
        wr(6'd13, 32'h2000_0000);
        rd("R11 ctrl after offset write", 6'd10, 32'h0002_0000);
        look(1'b1, 5'h08, 32'h1001_0000);
        expect_res("R11 disabled window misses", 1'b0, 3'd0, 32'd0);
        wr(6'd10, 32'h8002_0000);
        look(1'b1, 5'h08, 32'h1001_0000);
        expect_res("R11 re-enabled window hits", 1'b1, 3'd2, 32'h3001_0000);

        // R3 disable window 0: window 2 takes over
        wr(6'd0, 32'h0002_0000);
        look(1'b1, 5'h08, 32'h1000_0040);
        expect_res("R3 R8 disabled w0 falls to w2", 1'b1, 3'd2, 32'h3000_0040);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule